// File: doc/BRIEF.md
# Transport Stream Byte Output Stage

This block sits behind a packet decoder and delivers its 188-byte transport packets to the outside world over two paths at once. One is an 8-bit parallel bus with its own byte clock. The other is a 1-bit serial line with its own bit clock. Both paths carry a data-enable strobe, a packet-start strobe and a marker for packets the decoder could not correct. Each byte the decoder hands over occupies one fixed output slot of 16 system clock cycles. Both paths present that byte during the same slot: the parallel path as a whole word, the serial path as eight bits sent MSB first.

The decoder offers a byte with `in_valid`, marks the first byte of each packet with `in_sop`, and gives the packet's uncorrectable flag together with that first byte. The block has no handshake. A byte is taken when the slot machine is idle, or in the last cycle of a running slot. Upstream must pace its bytes to that rate, and offers made at any other time are dropped. For an uncorrectable packet the block can raise the error-indicator bit in the header byte that follows the sync byte. This is governed by two configuration bits. A single enable input switches the serial path on; when it is off, the serial outputs stay low.

The slot machine has two states. In SLOT_IDLE no byte is on the outputs. In SLOT_BUSY a byte is held and a 4-bit phase counter runs from 0 to 15. The transitions are:
- IDLE to BUSY (start): `in_valid` is high in SLOT_IDLE.
- BUSY to BUSY (chain): `in_valid` is high in phase 15.
- BUSY to IDLE (drain): `in_valid` is low in phase 15.

In every other BUSY cycle the machine stays in SLOT_BUSY and the phase counter advances.

Top module: `ts_stream_out`

## Requirements
- R1: After reset every output is low and the block is in SLOT_IDLE.
- R2: Each accepted byte opens a slot of exactly 16 cycles, beginning on the clock edge that samples `in_valid`. Throughout the slot `par_den` is high and `par_data` holds the byte, with R6 marking applied. Outside slots `par_den` and `par_data` are zero.
- R3: `par_clk` is low in slot phases 0 to 7 and high in phases 8 to 15, and low while idle. Its single rising edge therefore falls mid-slot, while `par_data` is stable.
- R4: `par_sync` is high for the whole slot of a byte offered with `in_sop` high, and low for all other bytes.
- R5: `in_uncorr` is sampled with the start-of-packet byte. `par_uncor` is high for the whole slot of that byte and of every following byte up to the next start-of-packet byte.
- R6: In an uncorrectable packet the first byte after the start-of-packet byte has bit 7 forced to 1 when `cfg_mark_off` equals 2'b00. With any nonzero `cfg_mark_off`, and for every other byte, the data pass unchanged.
- R7: With `ser_en` high, `ser_clk` is high in odd slot phases and low in even ones. `ser_data` carries bit (7 - phase/2) of the slot byte, so the MSB goes first. The data change only where `ser_clk` falls.
- R8: With `ser_en` high, `ser_den`, `ser_sync` and `ser_uncor` equal `par_den`, `par_sync` and `par_uncor` for every cycle of the slot.
- R9: With `ser_en` low, all five serial outputs stay low, and the parallel path behaves unchanged.
- R10: An `in_valid` in slot phases 0 to 14 is ignored: the byte, its flags and the packet state are left untouched. An `in_valid` in phase 15 starts the next slot on the following cycle, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_byte | input | 8 | Decoded byte offered by the decoder |
| in_valid | input | 1 | Offer strobe for `in_byte` |
| in_sop | input | 1 | Offered byte is the first (sync) byte of a packet |
| in_uncorr | input | 1 | Packet uncorrectable; sampled with the start-of-packet byte |
| cfg_mark_off | input | 2 | Header error marking enabled only when 2'b00 |
| ser_en | input | 1 | Serial path enable |
| par_clk | output | 1 | Parallel byte clock |
| par_data | output | 8 | Parallel byte |
| par_den | output | 1 | Parallel data enable |
| par_sync | output | 1 | Parallel packet-start strobe |
| par_uncor | output | 1 | Parallel uncorrectable-packet marker |
| ser_clk | output | 1 | Serial bit clock |
| ser_data | output | 1 | Serial data, MSB first |
| ser_den | output | 1 | Serial data enable |
| ser_sync | output | 1 | Serial packet-start strobe |
| ser_uncor | output | 1 | Serial uncorrectable-packet marker |

## Verification
The hardest conditions to reach from the ports are offers that land at an exact phase of a running slot. One is a stray offer in the middle of a slot, which must be dropped even when it claims to start a packet. The other is an offer in phase 15, which must chain into a new slot with no gap. The bench drives every byte from a task that counts the falling edges inside the slot. It places stray offers at phase 5 and chained offers at phase 15. It also walks every `cfg_mark_off` value, both flag values and both serial-enable settings, so that the single forced header bit is seen both set and withheld.

// File: rtl/ts_out_pkg.sv
package ts_out_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        SLOT_IDLE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              sync;
        logic              uncor;
    } ts_word_t;
endpackage

// File: rtl/ts_err_mark.sv
module ts_err_mark
    import ts_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_sop,
    input  logic              in_uncorr,
    input  logic [1:0]        cfg_mark_off,
    output ts_word_t          word
);
    logic pkt_bad;
    logic hdr_next;

    // packet state moves only on accepted bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_bad  <= 1'b0;
            hdr_next <= 1'b0;
        end else if (take) begin
            if (in_sop) pkt_bad <= in_uncorr;
            hdr_next <= in_sop;
        end
    end

    always_comb begin
        word.data  = in_byte;
        word.sync  = in_sop;
        word.uncor = in_sop ? in_uncorr : pkt_bad;
        if (!in_sop && hdr_next && pkt_bad && (cfg_mark_off == 2'b00))
            word.data[BYTE_W-1] = 1'b1;
    end
endmodule

// File: rtl/ts_ser_drive.sv
module ts_ser_drive
    import ts_out_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  ts_word_t        held,
    input  logic            busy,
    input  logic            ser_en,
    input  logic [PH_W-1:0] phase,
    output logic            ser_clk,
    output logic            ser_data,
    output logic            ser_den,
    output logic            ser_sync,
    output logic            ser_uncor
);
    logic          on;
    logic [PH_W-2:0] sel;

    assign on  = busy & ser_en;
    assign sel = phase[PH_W-1:1];

    always_comb begin
        ser_clk   = on & phase[0];
        ser_data  = on & held.data[~sel];
        ser_den   = on;
        ser_sync  = on & held.sync;
        ser_uncor = on & held.uncor;
    end
endmodule

// File: rtl/ts_stream_out.sv
module ts_stream_out
    import ts_out_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_uncorr,
    input  logic [1:0]        cfg_mark_off,
    input  logic              ser_en,
    output logic              par_clk,
    output logic [BYTE_W-1:0] par_data,
    output logic              par_den,
    output logic              par_sync,
    output logic              par_uncor,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_den,
    output logic              ser_sync,
    output logic              ser_uncor
);
    localparam int SLOT_LEN = 2 * BYTE_W;
    localparam int PH_W     = $clog2(SLOT_LEN);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_LEN - 1);

    slot_state_t     state;
    logic [PH_W-1:0] phase;
    ts_word_t        held;
    ts_word_t        next_word;
    logic            busy;
    logic            open_win;
    logic            take;

    assign busy     = (state == SLOT_BUSY);
    assign open_win = !busy || (phase == PH_LAST);
    assign take     = open_win && in_valid;

    ts_err_mark u_mark (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (take),
        .in_byte      (in_byte),
        .in_sop       (in_sop),
        .in_uncorr    (in_uncorr),
        .cfg_mark_off (cfg_mark_off),
        .word         (next_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SLOT_IDLE;
            phase <= '0;
            held  <= '0;
        end else begin
            unique case (state)
                SLOT_IDLE: begin
                    if (in_valid) begin
                        state <= SLOT_BUSY;
                        phase <= '0;
                        held  <= next_word;
                    end
                end
                SLOT_BUSY: begin
                    if (phase != PH_LAST) begin
                        phase <= phase + 1'b1;
                    end else if (in_valid) begin
                        phase <= '0;
                        held  <= next_word;
                    end else begin
                        state <= SLOT_IDLE;
                        phase <= '0;
                        held  <= '0;
                    end
                end
                default: state <= SLOT_IDLE;
            endcase
        end
    end

    // parallel outputs
    always_comb begin
        par_den   = busy;
        par_data  = busy ? held.data : '0;
        par_sync  = busy & held.sync;
        par_uncor = busy & held.uncor;
        par_clk   = busy & phase[PH_W-1];
    end

    ts_ser_drive #(.PH_W(PH_W)) u_ser (
        .held      (held),
        .busy      (busy),
        .ser_en    (ser_en),
        .phase     (phase),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_den   (ser_den),
        .ser_sync  (ser_sync),
        .ser_uncor (ser_uncor)
    );

    // R2
    den_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_den && phase != PH_LAST) |=> par_den);
    // R10
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_den && phase != PH_LAST) |=> $stable(par_data) && $stable(par_sync));
    // R3
    pclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_clk) |-> (par_den && $stable(par_data)));
    // R7
    sdat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_data));
    // R4
    sync_den_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_sync |-> par_den);
    // R5
    uncor_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_den && par_uncor && phase == PH_LAST && in_valid && !in_sop) |=> par_uncor);
endmodule

// File: tb/sim_ts_stream_out.sv
module sim_ts_stream_out;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_byte = '0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_uncorr = 1'b0;
    logic [1:0] cfg_mark_off = '0;
    logic       ser_en = 1'b0;
    logic       par_clk, par_den, par_sync, par_uncor;
    logic [7:0] par_data;
    logic       ser_clk, ser_data, ser_den, ser_sync, ser_uncor;

    int checks = 0;
    int errors = 0;
    logic m_bad = 1'b0, m_hdr = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    ts_stream_out u0 (.*);

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic idle_chk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R2 idle par_den", 8'(par_den), 8'd0);
            chk("R3 idle par_clk", 8'(par_clk), 8'd0);
            chk("R9 idle ser_clk/den", 8'({ser_clk, ser_den}), 8'd0);
        end
    endtask

    // called at a falling edge with the block idle or in phase 15
    task automatic slot(input logic [7:0] b, input logic sop, input logic unc, input logic stray);
        logic [7:0] ed;
        logic       eu;
        if (sop) begin m_bad = unc; end
        eu = sop ? unc : m_bad;
        ed = b;
        if (!sop && m_hdr && m_bad && cfg_mark_off == 2'b00) ed[7] = 1'b1;
        m_hdr = sop;
        in_byte = b; in_sop = sop; in_uncorr = unc; in_valid = 1'b1;
        @(posedge clk);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (k == 0) begin in_valid = 1'b0; in_sop = 1'b0; end
            if (k == 6) begin in_valid = 1'b0; in_sop = 1'b0; in_uncorr = 1'b0; end
            chk("R2 par_den", 8'(par_den), 8'd1);
            chk("R2/R6 par_data", par_data, ed);
            chk("R3 par_clk", 8'(par_clk), 8'(k >= 8));
            chk("R4 par_sync", 8'(par_sync), 8'(sop));
            chk("R5 par_uncor", 8'(par_uncor), 8'(eu));
            chk("R7 ser_clk", 8'(ser_clk), 8'(ser_en & k[0]));
            chk("R7 ser_data", 8'(ser_data), 8'(ser_en & ed[7 - k/2]));
            chk("R8/R9 ser strobes", 8'({ser_den, ser_sync, ser_uncor}),
                8'({ser_en, ser_en & sop, ser_en & eu}));
            if (stray && k == 5) begin
                // R10: offer mid-slot, must be dropped
                in_byte = ~b; in_sop = 1'b1; in_uncorr = ~eu; in_valid = 1'b1;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 par outputs", {par_clk, par_den, par_sync, par_uncor, 4'd0}, 8'd0);
        chk("R1 par_data", par_data, 8'd0);
        chk("R1 ser outputs", 8'({ser_clk, ser_data, ser_den, ser_sync, ser_uncor}), 8'd0);
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) begin
                for (int u = 0; u < 2; u++) begin
                    cfg_mark_off = 2'(c);
                    ser_en = s[0];
                    slot(8'h47, 1'b1, u[0], 1'b0);
                    for (int i = 1; i < 4; i++)
                        slot(8'((c * 37 + u * 11 + i * 53) & 8'h7F), 1'b0, u[0], u[0] & (i == 2));
                    if (s == 0) idle_chk(2);
                end
            end
            idle_chk(1);
        end
        // R10 chained slots of top-bit-set bytes with serial path on
        ser_en = 1'b1; cfg_mark_off = 2'b00;
        slot(8'h47, 1'b1, 1'b1, 1'b1);
        slot(8'hFF, 1'b0, 1'b1, 1'b0);
        slot(8'h80, 1'b0, 1'b0, 1'b1);
        idle_chk(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule